// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the arithmetic and logic datapath for a small 8-bit accumulator processor. Each request presents an operation code, the accumulator, the two index registers, a memory operand and the current status byte. The block computes the result byte, names the register that should receive it, and produces the new status byte. Only the negative, overflow, zero and carry flags are ever altered. Every other status bit is passed through unchanged.

The flag behaviour follows the classic NMOS conventions. On subtraction and comparison, carry is the inverse of borrow. Overflow is derived from the operand and result signs. One undocumented operation ANDs the accumulator with X, subtracts the operand, and writes the difference to X. Decimal arithmetic, instruction decoding and memory access belong to neighbouring blocks.

The result goes through a single register stage. A valid strobe marks the cycle in which a fresh result is presented, and the outputs hold their value between requests.

Top module: `alu8_unit`

## Requirements
- R1: Operation codes are LOAD=0, AND=1, OR=2, XOR=3. Each sets result to operand, A&operand, A|operand or A^operand respectively, with destination A (code 1). Only N (status bit 7, copied from result bit 7) and Z (bit 1, set when result is zero) change.
- R2: ADC (code 4) returns A+operand+C (C is status bit 0) to A. C takes bit 8 of the sum. V (bit 6) is set when A and the operand share a sign and the result sign differs from A. N and Z follow the result.
- R3: SBC (code 5) returns A-operand-(1-C) to A. C is set when no borrow occurs. V is set when A and the operand differ in sign and the result sign differs from A. N and Z follow the result.
- R4: Compares against A (6), X (7) and Y (8) have destination none (code 0) and return the low byte of register minus operand. They set C when register >= operand, set N and Z from that byte, and leave V unchanged.
- R5: BIT (code 9) has destination none and returns A&operand. It sets Z when that value is zero and copies operand bits 7 and 6 into N and V. C is unchanged.
- R6: ASL (10) and LSR (11) shift the operand into destination memory (code 3). ASL moves bit 7 into C. LSR moves bit 0 into C and always clears N. Z follows the result.
- R7: ROL (12) and ROR (13) rotate the operand through C into destination memory. The old C fills the vacated bit, and the bit shifted out becomes the new C. N and Z follow the result.
- R8: INC (14) and DEC (15) add or subtract one modulo 256 into destination memory. They change only N and Z.
- R9: AXS (16) writes (A&X)-operand to destination X (code 2). C is set on no borrow, N and Z follow the result, and V is unchanged.
- R10: Status bits 5..2 always pass through unchanged. Codes 17..31 return result 0 with destination none and the status byte unchanged.
- R11: A request with in_valid high appears on the outputs after the next rising edge, with out_valid high for exactly that cycle. Without a request, out_valid is low and the result, destination and status outputs hold.
- R12: While rst_n is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 5 | Operation code |
| acc | input | 8 | Accumulator value |
| xreg | input | 8 | X register value |
| yreg | input | 8 | Y register value |
| operand | input | 8 | Memory operand |
| status_in | input | 8 | Current status byte |
| out_valid | output | 1 | Fresh result this cycle |
| result | output | 8 | Result byte |
| dest | output | 2 | Destination: 0 none, 1 A, 2 X, 3 memory |
| status_out | output | 8 | Updated status byte |

## Verification
Two things can happen in the same cycle and are checked together.

First, several flags can change at once from a single add. Adding 0x80 to 0x80 wraps to zero and sets carry, overflow and zero together. Subtracting with a clear carry borrows and turns negative in one step. The vector table drives these cases, and each status byte is compared whole against a hand-derived value.

Second, the register stage can present one result while it captures the next. Two requests are issued on consecutive cycles. The bench confirms that each result appears on its own cycle with the strobe held high, and that the outputs freeze once requests stop.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_LOAD = 5'd0,  OP_AND  = 5'd1,  OP_OR   = 5'd2,  OP_XOR  = 5'd3,
    OP_ADC  = 5'd4,  OP_SBC  = 5'd5,  OP_CMPA = 5'd6,  OP_CMPX = 5'd7,
    OP_CMPY = 5'd8,  OP_BIT  = 5'd9,  OP_ASL  = 5'd10, OP_LSR  = 5'd11,
    OP_ROL  = 5'd12, OP_ROR  = 5'd13, OP_INC  = 5'd14, OP_DEC  = 5'd15,
    OP_AXS  = 5'd16
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0, DST_ACC = 2'd1, DST_XREG = 2'd2, DST_MEM = 2'd3
  } alu_dst_e;

  localparam int FLG_N = 7;
  localparam int FLG_V = 6;
  localparam int FLG_Z = 1;
  localparam int FLG_C = 0;

  // Signed overflow of lhs + rhs: equal input signs, different result sign.
  function automatic logic sum_overflow(input logic lhs_msb, input logic rhs_msb,
                                        input logic res_msb);
    return (lhs_msb == rhs_msb) && (res_msb != lhs_msb);
  endfunction

endpackage

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [4:0]    op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] xreg,
  input  logic [DW-1:0] yreg,
  input  logic [DW-1:0] operand,
  input  logic [7:0]    status_in,
  output logic [DW-1:0] res,
  output logic [1:0]    dst,
  output logic [7:0]    status_nx,
  output logic          add_carry,
  output logic          add_ovf
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] lhs, rhs;
  logic          cin;
  logic [DW:0]   sum;
  logic          upd_nz;
  logic          n_nx, v_nx, z_nx, c_nx;

  // Shared adder: subtract and compare use the inverted operand.
  always_comb begin
    lhs = acc;
    rhs = operand;
    cin = status_in[FLG_C];
    case (op)
      OP_SBC:  rhs = ~operand;
      OP_CMPA: begin rhs = ~operand; cin = 1'b1; end
      OP_CMPX: begin lhs = xreg; rhs = ~operand; cin = 1'b1; end
      OP_CMPY: begin lhs = yreg; rhs = ~operand; cin = 1'b1; end
      OP_AXS:  begin lhs = acc & xreg; rhs = ~operand; cin = 1'b1; end
      default: ;
    endcase
  end

  assign sum       = {1'b0, lhs} + {1'b0, rhs} + {{DW{1'b0}}, cin};
  assign add_carry = sum[DW];
  assign add_ovf   = sum_overflow(lhs[MSB], rhs[MSB], sum[MSB]);

  always_comb begin
    res    = '0;
    dst    = DST_NONE;
    upd_nz = 1'b1;
    n_nx   = status_in[FLG_N];
    v_nx   = status_in[FLG_V];
    z_nx   = status_in[FLG_Z];
    c_nx   = status_in[FLG_C];
    case (op)
      OP_LOAD: begin res = operand;       dst = DST_ACC; end
      OP_AND:  begin res = acc & operand; dst = DST_ACC; end
      OP_OR:   begin res = acc | operand; dst = DST_ACC; end
      OP_XOR:  begin res = acc ^ operand; dst = DST_ACC; end
      OP_ADC, OP_SBC: begin
        res  = sum[MSB:0];
        dst  = DST_ACC;
        c_nx = add_carry;
        v_nx = add_ovf;
      end
      OP_CMPA, OP_CMPX, OP_CMPY: begin
        res  = sum[MSB:0];
        c_nx = add_carry;
      end
      OP_AXS: begin
        res  = sum[MSB:0];
        dst  = DST_XREG;
        c_nx = add_carry;
      end
      OP_BIT: begin
        res    = acc & operand;
        upd_nz = 1'b0;
        z_nx   = ~|res;
        n_nx   = operand[MSB];
        v_nx   = operand[MSB-1];
      end
      OP_ASL: begin res = {operand[MSB-1:0], 1'b0};              dst = DST_MEM; c_nx = operand[MSB]; end
      OP_LSR: begin res = {1'b0, operand[MSB:1]};                dst = DST_MEM; c_nx = operand[0];   end
      OP_ROL: begin res = {operand[MSB-1:0], status_in[FLG_C]};  dst = DST_MEM; c_nx = operand[MSB]; end
      OP_ROR: begin res = {status_in[FLG_C], operand[MSB:1]};    dst = DST_MEM; c_nx = operand[0];   end
      OP_INC: begin res = operand + {{(DW-1){1'b0}}, 1'b1};      dst = DST_MEM; end
      OP_DEC: begin res = operand - {{(DW-1){1'b0}}, 1'b1};      dst = DST_MEM; end
      default: upd_nz = 1'b0;
    endcase
    if (upd_nz) begin
      n_nx = res[MSB];
      z_nx = ~|res;
    end
  end

  assign status_nx = {n_nx, v_nx, status_in[5:2], z_nx, c_nx};

endmodule

// File: rtl/alu8_outreg.sv
module alu8_outreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d_res,
  input  logic [1:0]    d_dst,
  input  logic [7:0]    d_stat,
  output logic          q_valid,
  output logic [DW-1:0] q_res,
  output logic [1:0]    q_dst,
  output logic [7:0]    q_stat
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_res   <= '0;
      q_dst   <= '0;
      q_stat  <= '0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_res  <= d_res;
        q_dst  <= d_dst;
        q_stat <= d_stat;
      end
    end
  end

  // R11
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q_valid);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> !q_valid && $stable(q_res) && $stable(q_stat) && $stable(q_dst));

endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [4:0]    op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] xreg,
  input  logic [DW-1:0] yreg,
  input  logic [DW-1:0] operand,
  input  logic [7:0]    status_in,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic [1:0]    dest,
  output logic [7:0]    status_out
);
  logic [DW-1:0] core_res;
  logic [1:0]    core_dst;
  logic [7:0]    core_stat;
  logic          add_carry, add_ovf;

  alu8_core #(.DW(DW)) core_i (
    .op        (op),
    .acc       (acc),
    .xreg      (xreg),
    .yreg      (yreg),
    .operand   (operand),
    .status_in (status_in),
    .res       (core_res),
    .dst       (core_dst),
    .status_nx (core_stat),
    .add_carry (add_carry),
    .add_ovf   (add_ovf)
  );

  alu8_outreg #(.DW(DW)) oreg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_valid),
    .d_res   (core_res),
    .d_dst   (core_dst),
    .d_stat  (core_stat),
    .q_valid (out_valid),
    .q_res   (result),
    .q_dst   (dest),
    .q_stat  (status_out)
  );

  // R10
  passthru_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> status_out[5:2] == $past(status_in[5:2]));

  // R4
  cmp_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op == OP_CMPA || op == OP_CMPX || op == OP_CMPY)
    |=> dest == DST_NONE && status_out[FLG_V] == $past(status_in[FLG_V]));

  // R5
  bit_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_BIT
    |=> status_out[FLG_N] == $past(operand[DW-1]) && status_out[FLG_V] == $past(operand[DW-2]));

  // R6
  lsr_clears_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_LSR |=> !status_out[FLG_N] && dest == DST_MEM);

  // R2
  adc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_ADC |=> status_out[FLG_C] == $past(add_carry));

endmodule

// File: tb/alu8_unit_tb.sv
module alu8_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] acc = '0, xreg = '0, yreg = '0, operand = '0, status_in = '0;
  logic       out_valid;
  logic [7:0] result, status_out;
  logic [1:0] dest;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  alu8_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .acc(acc),
    .xreg(xreg), .yreg(yreg), .operand(operand), .status_in(status_in),
    .out_valid(out_valid), .result(result), .dest(dest), .status_out(status_out)
  );

  // Fields: op, a, x, y, m, p_in, exp_result, exp_dest, exp_p
  localparam int NV = 29;
  localparam logic [62:0] VEC [NV] = '{
    {5'd0,  8'h00, 8'h00, 8'h00, 8'h80, 8'h24, 8'h80, 2'd1, 8'hA4},
    {5'd0,  8'h00, 8'h00, 8'h00, 8'h00, 8'hA4, 8'h00, 2'd1, 8'h26},
    {5'd1,  8'hF0, 8'h00, 8'h00, 8'h0F, 8'h20, 8'h00, 2'd1, 8'h22},
    {5'd2,  8'hF0, 8'h00, 8'h00, 8'h0F, 8'h22, 8'hFF, 2'd1, 8'hA0},
    {5'd3,  8'hFF, 8'h00, 8'h00, 8'hFF, 8'hA1, 8'h00, 2'd1, 8'h23},
    {5'd4,  8'h50, 8'h00, 8'h00, 8'h50, 8'h20, 8'hA0, 2'd1, 8'hE0},
    {5'd4,  8'h80, 8'h00, 8'h00, 8'h80, 8'h20, 8'h00, 2'd1, 8'h63},
    {5'd4,  8'hFF, 8'h00, 8'h00, 8'h00, 8'h21, 8'h00, 2'd1, 8'h23},
    {5'd5,  8'h50, 8'h00, 8'h00, 8'hF0, 8'h21, 8'h60, 2'd1, 8'h20},
    {5'd5,  8'h50, 8'h00, 8'h00, 8'hB0, 8'h21, 8'hA0, 2'd1, 8'hE0},
    {5'd5,  8'h00, 8'h00, 8'h00, 8'h00, 8'h20, 8'hFF, 2'd1, 8'hA0},
    {5'd5,  8'h05, 8'h00, 8'h00, 8'h03, 8'hE1, 8'h02, 2'd1, 8'h21},
    {5'd6,  8'h40, 8'h00, 8'h00, 8'h40, 8'h60, 8'h00, 2'd0, 8'h63},
    {5'd7,  8'hFF, 8'h10, 8'h00, 8'h20, 8'h20, 8'hF0, 2'd0, 8'hA0},
    {5'd8,  8'h00, 8'h00, 8'hFF, 8'h01, 8'h20, 8'hFE, 2'd0, 8'hA1},
    {5'd9,  8'h01, 8'h00, 8'h00, 8'hC0, 8'h20, 8'h00, 2'd0, 8'hE2},
    {5'd9,  8'h41, 8'h00, 8'h00, 8'h41, 8'hE3, 8'h41, 2'd0, 8'h61},
    {5'd10, 8'h00, 8'h00, 8'h00, 8'h81, 8'h20, 8'h02, 2'd3, 8'h21},
    {5'd11, 8'h00, 8'h00, 8'h00, 8'h01, 8'hA0, 8'h00, 2'd3, 8'h23},
    {5'd12, 8'h00, 8'h00, 8'h00, 8'h80, 8'h21, 8'h01, 2'd3, 8'h21},
    {5'd13, 8'h00, 8'h00, 8'h00, 8'h01, 8'h20, 8'h00, 2'd3, 8'h23},
    {5'd13, 8'h00, 8'h00, 8'h00, 8'h02, 8'h21, 8'h81, 2'd3, 8'hA0},
    {5'd14, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h21, 8'h00, 2'd3, 8'h23},
    {5'd14, 8'h00, 8'h00, 8'h00, 8'h7F, 8'h3D, 8'h80, 2'd3, 8'hBD},
    {5'd15, 8'h00, 8'h00, 8'h00, 8'h00, 8'h22, 8'hFF, 2'd3, 8'hA0},
    {5'd16, 8'hF3, 8'h3C, 8'h00, 8'h10, 8'h20, 8'h20, 2'd2, 8'h21},
    {5'd16, 8'h0F, 8'hFF, 8'h00, 8'h20, 8'h61, 8'hEF, 2'd2, 8'hE0},
    {5'd31, 8'h12, 8'h34, 8'h56, 8'h55, 8'hC3, 8'h00, 2'd0, 8'hC3},
    {5'd17, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h1C, 8'h00, 2'd0, 8'h1C}
  };

  function automatic string req_of(input logic [4:0] c);
    if (c <= 5'd3)       return "R1";
    else if (c == 5'd4)  return "R2";
    else if (c == 5'd5)  return "R3";
    else if (c <= 5'd8)  return "R4";
    else if (c == 5'd9)  return "R5";
    else if (c <= 5'd11) return "R6";
    else if (c <= 5'd13) return "R7";
    else if (c <= 5'd15) return "R8";
    else if (c == 5'd16) return "R9";
    return "R10";
  endfunction

  task automatic drive(input logic [62:0] v);
    op        = v[62:58];
    acc       = v[57:50];
    xreg      = v[49:42];
    yreg      = v[41:34];
    operand   = v[33:26];
    status_in = v[25:18];
    in_valid  = 1'b1;
  endtask

  task automatic judge(input logic [62:0] v, input int idx);
    checks++;
    if (out_valid !== 1'b1 || result !== v[17:10] || dest !== v[9:8] || status_out !== v[7:0]) begin
      fails++;
      $display("FAIL %s vec %0d op %0d: got v=%b r=%h d=%0d p=%h, expected v=1 r=%h d=%0d p=%h",
               req_of(v[62:58]), idx, v[62:58], out_valid, result, dest, status_out,
               v[17:10], v[9:8], v[7:0]);
    end
  endtask

  task automatic expect_outs(input string tag, input logic v, input logic [7:0] r,
                             input logic [1:0] d, input logic [7:0] p);
    checks++;
    if (out_valid !== v || result !== r || dest !== d || status_out !== p) begin
      fails++;
      $display("FAIL %s: got v=%b r=%h d=%0d p=%h, expected v=%b r=%h d=%0d p=%h",
               tag, out_valid, result, dest, status_out, v, r, d, p);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: outputs cleared while in reset
    expect_outs("R12 reset state", 1'b0, 8'h00, 2'd0, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      in_valid = 1'b0;
      judge(VEC[i], i);
    end

    // R11: idle cycles hold the last result with the strobe low
    drive(VEC[5]);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    expect_outs("R11 idle hold", 1'b0, VEC[NV-1][17:10], VEC[NV-1][9:8], VEC[NV-1][7:0]);

    // R11: back-to-back requests, R2 carry/overflow/zero at once then R3 borrow
    drive(VEC[6]);
    @(negedge clk);
    judge(VEC[6], 6);
    drive(VEC[10]);
    @(negedge clk);
    in_valid = 1'b0;
    judge(VEC[10], 10);
    @(negedge clk);
    expect_outs("R11 strobe single cycle", 1'b0, VEC[10][17:10], VEC[10][9:8], VEC[10][7:0]);

    // R12: reset in mid-run clears held outputs
    rst_n = 1'b0;
    drive(VEC[0]);
    @(negedge clk);
    in_valid = 1'b0;
    expect_outs("R12 reset clears", 1'b0, 8'h00, 2'd0, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule